// File: doc/BRIEF.md
# TLB Maintenance Register Port

This block is the special-register window that software uses to maintain a translation buffer. Each access names one of six registers through a 3-bit code. Four of them hold state in the block: the entry pointer, the process ID, the zone protection word and the search result. The other two are windows onto the entry store, the tag word and the data word. A tag or data access moves one 32-bit word between the register port and the entry that the entry pointer selects. An extended flag on a data-word access reaches the upper half of the 64-bit data word.

Tag reads and tag writes also move the entry's 8-bit translation ID to or from the process ID register. A write to the search register does not run a lookup in this block. It passes the page number to a separate lookup engine through a request pulse. When the engine answers, the entry pointer takes the hit index, or takes a miss flag in its top bit.

Two configuration inputs set what software may reach: an MMU level and a 2-bit TLB-access setting. An access that is not allowed raises an error pulse, reads back zero and changes nothing.

Top module: `tlb_mgmt_regs`

## Requirements
- R1: Bits 7:0 of the entry pointer (code 2) select the entry that tag-word (code 1) and data-word (code 0) accesses reach. A tag or data access while that index is ENTRIES or more is rejected.
- R2: A tag write stores the written word and copies bits 7:0 of the process ID (code 3) into the selected entry's translation ID.
- R3: A tag read returns the stored word and loads the process ID with the entry's translation ID, zero-extended.
- R4: The extended flag is legal only with code 0, where it reaches bits 63:32 of the data word. Without the flag, code 0 reaches bits 31:0. The flag with any other code is rejected.
- R5: Bit 31 of the entry pointer cannot be written by software. A write updates bits 30:0 only.
- R6: An accepted write of code 5 raises `srch_req` for one cycle, one cycle later, with the written word on `srch_vpn`. When `srch_done` arrives, the entry pointer becomes the zero-extended `srch_idx` on a hit, or 0x8000_0000 on a miss.
- R7: A read of code 5, and any access with code 6 or 7, is rejected.
- R8: Every access is rejected while `cfg_level` is below 2 or `cfg_tlb_acc` is 0.
- R9: Writes of codes 3, 4 and 5 are rejected while `cfg_tlb_acc` is 1 or less. Reads of codes 0, 1, 3 and 4 are rejected while `cfg_tlb_acc` bit 0 is clear.
- R10: A rejected access pulses `acc_err` in the cycle after the access. A rejected read also returns `rd_valid` with zero data. No register or entry changes.
- R11: After reset the entry pointer, process ID and zone word read 0. Every entry reads 0 in its tag, in both data halves and in its translation ID.
- R12: `rd_valid` and `rd_data` appear exactly one cycle after each read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_ext | input | 1 | Extended (upper-half) access |
| acc_sel | input | 3 | Register code: 0 data, 1 tag, 2 pointer, 3 process ID, 4 zone, 5 search |
| acc_wdata | input | DW | Write data |
| cfg_level | input | 2 | MMU configuration level |
| cfg_tlb_acc | input | 2 | TLB-access configuration |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DW | Read data |
| acc_err | output | 1 | Rejected-access pulse |
| srch_req | output | 1 | Search request to the lookup engine |
| srch_vpn | output | DW | Page number to search for |
| srch_done | input | 1 | Lookup engine answer strobe |
| srch_hit | input | 1 | Answer found a matching entry |
| srch_idx | input | 8 | Index of the matching entry |

## Verification
A reference model in the bench is driven with several kinds of sequence. Interleaved pointer, process-ID and tag traffic across separate entries shows whether the index selects the right storage and whether the ID moves in the correct direction on reads and on writes. Extended and plain data-word accesses tell the two halves apart. Search answers of both kinds, followed by pointer writes, separate the read-only top bit from the writable bits. Sweeps of the two configuration inputs through every gated access, each followed by a read-back under full permission, show that a rejection leaves the state untouched.

// File: rtl/tlbreg_pkg.sv
package tlbreg_pkg;
  typedef enum logic [2:0] {
    SEL_LO   = 3'd0,
    SEL_HI   = 3'd1,
    SEL_IDX  = 3'd2,
    SEL_PID  = 3'd3,
    SEL_ZPR  = 3'd4,
    SEL_SRCH = 3'd5
  } tlbreg_sel_e;

  localparam int NUM_BANKS = 3;  // tag, data low, data high
  localparam int BANK_TAG  = 0;
  localparam int BANK_LO   = 1;
  localparam int BANK_UP   = 2;
endpackage

// File: rtl/tlbreg_check.sv
module tlbreg_check
  import tlbreg_pkg::*;
(
  input  logic       acc_valid,
  input  logic       acc_write,
  input  logic       acc_ext,
  input  logic [2:0] acc_sel,
  input  logic [1:0] cfg_level,
  input  logic [1:0] cfg_tlb_acc,
  input  logic       idx_ok,
  output logic       acc_ok,
  output logic       acc_bad
);
  logic is_entry, is_priv, bad;

  always_comb begin
    is_entry = (acc_sel == SEL_LO) || (acc_sel == SEL_HI);
    is_priv  = (acc_sel == SEL_PID) || (acc_sel == SEL_ZPR);
    bad      = 1'b0;
    if (cfg_level < 2'd2 || cfg_tlb_acc == 2'd0) bad = 1'b1;
    if (acc_sel > SEL_SRCH) bad = 1'b1;
    if (acc_ext && acc_sel != SEL_LO) bad = 1'b1;
    if (is_entry && !idx_ok) bad = 1'b1;
    if (acc_write) begin
      if ((is_priv || acc_sel == SEL_SRCH) && cfg_tlb_acc <= 2'd1) bad = 1'b1;
    end else begin
      if (acc_sel == SEL_SRCH) bad = 1'b1;
      if ((is_entry || is_priv) && !cfg_tlb_acc[0]) bad = 1'b1;
    end
  end

  assign acc_ok  = acc_valid && !bad;
  assign acc_bad = acc_valid && bad;
endmodule

// File: rtl/tlbreg_store.sv
module tlbreg_store
  import tlbreg_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int DW      = 32,
  parameter int ID_W    = 8,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        idx,
  input  logic [NUM_BANKS-1:0] wr_en,
  input  logic [NUM_BANKS-1:0] rd_en,
  input  logic [DW-1:0]        wdata,
  input  logic [ID_W-1:0]      tid_in,
  output logic [ID_W-1:0]      tid_out,
  output logic [DW-1:0]        rd_data
);
  logic [NUM_BANKS-1:0][DW-1:0] bank_q;
  logic [1:0]                   sel_q;
  logic [ID_W-1:0]              tid [ENTRIES];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DW-1:0]      mem [ENTRIES];
    logic [ENTRIES-1:0] vld;
    logic [DW-1:0]      q;

    always_ff @(posedge clk) begin
      if (wr_en[b]) mem[idx] <= wdata;
    end

    always_ff @(posedge clk) begin
      if (rst) vld <= '0;
      else if (wr_en[b]) vld[idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (rd_en[b]) q <= vld[idx] ? mem[idx] : '0;
    end

    assign bank_q[b] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (rd_en[BANK_UP]) sel_q <= 2'(BANK_UP);
    else if (rd_en[BANK_LO]) sel_q <= 2'(BANK_LO);
    else if (rd_en[BANK_TAG]) sel_q <= 2'(BANK_TAG);
  end

  always_comb begin
    case (sel_q)
      2'(BANK_TAG): rd_data = bank_q[BANK_TAG];
      2'(BANK_LO):  rd_data = bank_q[BANK_LO];
      2'(BANK_UP):  rd_data = bank_q[BANK_UP];
      default:      rd_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) tid[i] <= '0;
    end else if (wr_en[BANK_TAG]) begin
      tid[idx] <= tid_in;
    end
  end

  assign tid_out = tid[idx];

  AST_TID_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    wr_en[BANK_TAG] |=> tid[$past(idx)] == $past(tid_in)); // R2
  AST_ONE_BANK_WR: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en)); // R4
endmodule

// File: rtl/tlbreg_regs.sv
module tlbreg_regs #(
  parameter int DW   = 32,
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            idx_we,
  input  logic            pid_we,
  input  logic            zpr_we,
  input  logic            pid_load,
  input  logic [ID_W-1:0] tid_in,
  input  logic [DW-1:0]   wdata,
  input  logic            srch_done,
  input  logic            srch_hit,
  input  logic [ID_W-1:0] srch_idx,
  output logic [DW-1:0]   tlbx,
  output logic [DW-1:0]   pid,
  output logic [DW-1:0]   zpr
);
  localparam logic [DW-1:0] MISS_WORD = {1'b1, {(DW-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      tlbx <= '0;
      pid  <= '0;
      zpr  <= '0;
    end else begin
      if (srch_done) tlbx <= srch_hit ? {{(DW-ID_W){1'b0}}, srch_idx} : MISS_WORD;
      else if (idx_we) tlbx[DW-2:0] <= wdata[DW-2:0];
      if (pid_load) pid <= {{(DW-ID_W){1'b0}}, tid_in};
      else if (pid_we) pid <= wdata;
      if (zpr_we) zpr <= wdata;
    end
  end

  AST_TLBX_MSB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (idx_we && !srch_done) |=> tlbx[DW-1] == $past(tlbx[DW-1])); // R5
  AST_PID_FROM_ID: assert property (@(posedge clk) disable iff (rst)
    pid_load |=> pid[DW-1:ID_W] == '0); // R3
endmodule

// File: rtl/tlb_mgmt_regs.sv
module tlb_mgmt_regs
  import tlbreg_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int DW      = 32,
  parameter int ID_W    = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic            acc_ext,
  input  logic [2:0]      acc_sel,
  input  logic [DW-1:0]   acc_wdata,
  input  logic [1:0]      cfg_level,
  input  logic [1:0]      cfg_tlb_acc,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic            acc_err,
  output logic            srch_req,
  output logic [DW-1:0]   srch_vpn,
  input  logic            srch_done,
  input  logic            srch_hit,
  input  logic [ID_W-1:0] srch_idx
);
  localparam int AW = $clog2(ENTRIES);

  logic                 acc_ok, acc_bad, idx_ok;
  logic [ID_W-1:0]      idx_full, tid_cur;
  logic [DW-1:0]        tlbx_w, pid_w, zpr_w, mem_rd, csr_q;
  logic [NUM_BANKS-1:0] wr_en, rd_en;
  logic                 ok_wr, ok_rd, from_mem_q;

  assign idx_full = tlbx_w[ID_W-1:0];
  assign idx_ok   = (32'(idx_full) < ENTRIES);
  assign ok_wr    = acc_ok && acc_write;
  assign ok_rd    = acc_ok && !acc_write;

  assign wr_en[BANK_TAG] = ok_wr && acc_sel == SEL_HI;
  assign wr_en[BANK_LO]  = ok_wr && acc_sel == SEL_LO && !acc_ext;
  assign wr_en[BANK_UP]  = ok_wr && acc_sel == SEL_LO && acc_ext;
  assign rd_en[BANK_TAG] = ok_rd && acc_sel == SEL_HI;
  assign rd_en[BANK_LO]  = ok_rd && acc_sel == SEL_LO && !acc_ext;
  assign rd_en[BANK_UP]  = ok_rd && acc_sel == SEL_LO && acc_ext;

  tlbreg_check u_check (
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_ext    (acc_ext),
    .acc_sel    (acc_sel),
    .cfg_level  (cfg_level),
    .cfg_tlb_acc(cfg_tlb_acc),
    .idx_ok     (idx_ok),
    .acc_ok     (acc_ok),
    .acc_bad    (acc_bad)
  );

  tlbreg_store #(.ENTRIES(ENTRIES), .DW(DW), .ID_W(ID_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .idx    (idx_full[AW-1:0]),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .wdata  (acc_wdata),
    .tid_in (pid_w[ID_W-1:0]),
    .tid_out(tid_cur),
    .rd_data(mem_rd)
  );

  tlbreg_regs #(.DW(DW), .ID_W(ID_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .idx_we   (ok_wr && acc_sel == SEL_IDX),
    .pid_we   (ok_wr && acc_sel == SEL_PID),
    .zpr_we   (ok_wr && acc_sel == SEL_ZPR),
    .pid_load (rd_en[BANK_TAG]),
    .tid_in   (tid_cur),
    .wdata    (acc_wdata),
    .srch_done(srch_done),
    .srch_hit (srch_hit),
    .srch_idx (srch_idx),
    .tlbx     (tlbx_w),
    .pid      (pid_w),
    .zpr      (zpr_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      acc_err    <= 1'b0;
      from_mem_q <= 1'b0;
      csr_q      <= '0;
      srch_req   <= 1'b0;
      srch_vpn   <= '0;
    end else begin
      rd_valid   <= acc_valid && !acc_write;
      acc_err    <= acc_bad;
      from_mem_q <= |rd_en;
      csr_q      <= '0;
      if (ok_rd) begin
        case (acc_sel)
          SEL_IDX: csr_q <= tlbx_w;
          SEL_PID: csr_q <= pid_w;
          SEL_ZPR: csr_q <= zpr_w;
          default: csr_q <= '0;
        endcase
      end
      srch_req <= ok_wr && acc_sel == SEL_SRCH;
      if (ok_wr && acc_sel == SEL_SRCH) srch_vpn <= acc_wdata;
    end
  end

  assign rd_data = from_mem_q ? mem_rd : csr_q;

  AST_GATE_REJECT: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && (cfg_level < 2'd2 || cfg_tlb_acc == 2'd0)) |=> acc_err); // R8
  AST_EXT_ONLY_LO: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_ext && acc_sel != SEL_LO) |=> acc_err); // R4
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acc_err && rd_valid) |-> rd_data == '0); // R10
  AST_SRCH_SRC: assert property (@(posedge clk) disable iff (rst)
    srch_req |-> $past(acc_valid && acc_write && acc_sel == SEL_SRCH)); // R6
  AST_SRCH_MISS: assert property (@(posedge clk) disable iff (rst)
    (srch_done && !srch_hit) |=> tlbx_w[DW-1]); // R6
  AST_READ_LAT: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |=> rd_valid); // R12
  AST_SRCH_RD_ERR: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write && acc_sel == SEL_SRCH) |=> acc_err); // R7
endmodule

// File: tb/tb_tlb_mgmt_regs.sv
`timescale 1ns/100ps
module tb_tlb_mgmt_regs;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_ext = 1'b0;
  logic [2:0]  acc_sel = '0;
  logic [31:0] acc_wdata = '0;
  logic [1:0]  cfg_level = 2'd2, cfg_tlb_acc = 2'd3;
  logic        rd_valid, acc_err, srch_req;
  logic [31:0] rd_data, srch_vpn;
  logic        srch_done = 1'b0, srch_hit = 1'b0;
  logic [7:0]  srch_idx = '0;

  always #2.5 clk = ~clk;

  tlb_mgmt_regs #(.ENTRIES(N)) dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_ext(acc_ext), .acc_sel(acc_sel), .acc_wdata(acc_wdata),
    .cfg_level(cfg_level), .cfg_tlb_acc(cfg_tlb_acc), .rd_valid(rd_valid),
    .rd_data(rd_data), .acc_err(acc_err), .srch_req(srch_req),
    .srch_vpn(srch_vpn), .srch_done(srch_done), .srch_hit(srch_hit),
    .srch_idx(srch_idx)
  );

  typedef struct {
    logic        rv;
    logic        er;
    logic [31:0] d;
    string       rq;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   checks = 0, fails = 0;
  bit   done = 0;

  // reference model
  logic [31:0] mtag [N];
  logic [31:0] mlo  [N];
  logic [31:0] mup  [N];
  logic [7:0]  mtid [N];
  logic [31:0] mtlbx = '0, mpid = '0, mzpr = '0;

  function automatic bit legal(bit we, bit ext, logic [2:0] sel);
    if (cfg_level < 2 || cfg_tlb_acc == 0) return 0;
    if (sel > 5) return 0;
    if (ext && sel != 0) return 0;
    if ((sel == 0 || sel == 1) && mtlbx[7:0] >= N) return 0;
    if (we) begin
      if (sel >= 3 && cfg_tlb_acc < 2) return 0;
    end else begin
      if (sel == 5) return 0;
      if (sel != 2 && !cfg_tlb_acc[0]) return 0;
    end
    return 1;
  endfunction

  task automatic acc(input bit we, input bit ext, input logic [2:0] sel,
                     input logic [31:0] wd, input string rq);
    exp_t e;
    bit   ok = legal(we, ext, sel);
    int   i = int'(mtlbx[7:0]);
    e.rv = !we; e.er = !ok; e.d = '0; e.rq = rq;
    if (ok && !we) begin
      case (sel)
        3'd0: e.d = ext ? mup[i] : mlo[i];
        3'd1: e.d = mtag[i];
        3'd2: e.d = mtlbx;
        3'd3: e.d = mpid;
        3'd4: e.d = mzpr;
        default: e.d = '0;
      endcase
    end
    if (ok) begin
      if (we) begin
        case (sel)
          3'd0: if (ext) mup[i] = wd; else mlo[i] = wd;
          3'd1: begin mtag[i] = wd; mtid[i] = mpid[7:0]; end
          3'd2: mtlbx = {mtlbx[31], wd[30:0]};
          3'd3: mpid = wd;
          3'd4: mzpr = wd;
          default: ;
        endcase
      end else if (sel == 3'd1) begin
        mpid = {24'b0, mtid[i]};
      end
    end
    acc_valid = 1'b1; acc_write = we; acc_ext = ext; acc_sel = sel; acc_wdata = wd;
    @(posedge clk);
    q.push_back(e);
    @(negedge clk);
    acc_valid = 1'b0; acc_ext = 1'b0;
  endtask

  task automatic srch(input logic [31:0] vpn, input bit hit, input logic [7:0] id,
                      input string rq);
    bit lg = legal(1'b1, 1'b0, 3'd5);
    acc(1'b1, 1'b0, 3'd5, vpn, rq);
    checks++;
    if (srch_req !== lg || (lg && srch_vpn !== vpn)) begin
      fails++;
      $display("FAIL %s search request: act req=%0b vpn=%h exp req=%0b vpn=%h",
               rq, srch_req, srch_vpn, lg, vpn);
    end
    if (lg) begin
      srch_done = 1'b1; srch_hit = hit; srch_idx = id;
      @(negedge clk);
      srch_done = 1'b0;
      mtlbx = hit ? {24'b0, id} : 32'h8000_0000;
    end
  endtask

  // monitor: compares each result against the queued expectation
  always @(negedge clk) begin
    if (q.size() > 0) begin
      cur = q.pop_front();
      checks++;
      if (rd_valid !== cur.rv || acc_err !== cur.er || (cur.rv && rd_data !== cur.d)) begin
        fails++;
        $display("FAIL %s: act rv=%0b err=%0b data=%h exp rv=%0b err=%0b data=%h",
                 cur.rq, rd_valid, acc_err, rd_data, cur.rv, cur.er, cur.d);
      end
    end else if (!rst && (rd_valid || acc_err)) begin
      checks++; fails++;
      $display("FAIL R12: act unexpected rv=%0b err=%0b exp none", rd_valid, acc_err);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mtag[i] = '0; mlo[i] = '0; mup[i] = '0; mtid[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    acc(0, 0, 3'd2, 0, "R11");
    acc(0, 0, 3'd3, 0, "R11");
    acc(0, 0, 3'd4, 0, "R11");
    acc(0, 0, 3'd1, 0, "R11");
    acc(0, 0, 3'd0, 0, "R11");
    acc(0, 1, 3'd0, 0, "R11");

    // R2 / R3 / R4 / R1 entry traffic
    acc(1, 0, 3'd3, 32'h0000_01A5, "R2");
    acc(1, 0, 3'd2, 32'd5, "R1");
    acc(1, 0, 3'd1, 32'h1234_5678, "R2");
    acc(1, 0, 3'd0, 32'hAAAA_0001, "R4");
    acc(1, 1, 3'd0, 32'hBBBB_0002, "R4");
    acc(1, 0, 3'd3, 32'h0000_0033, "R3");
    acc(0, 0, 3'd1, 0, "R3");
    acc(0, 0, 3'd3, 0, "R3");
    acc(0, 0, 3'd0, 0, "R4");
    acc(0, 1, 3'd0, 0, "R4");
    acc(1, 0, 3'd2, 32'd6, "R1");
    acc(0, 0, 3'd1, 0, "R1");
    acc(0, 0, 3'd3, 0, "R3");
    acc(1, 0, 3'd2, 32'd63, "R1");
    acc(1, 0, 3'd3, 32'h0000_007E, "R2");
    acc(1, 0, 3'd1, 32'hCAFE_0000, "R2");
    acc(1, 0, 3'd3, 32'h0, "R2");
    acc(1, 0, 3'd2, 32'd5, "R1");
    acc(0, 0, 3'd0, 0, "R1");
    acc(0, 1, 3'd0, 0, "R1");
    acc(1, 0, 3'd2, 32'd63, "R1");
    acc(0, 0, 3'd1, 0, "R1");
    acc(0, 0, 3'd3, 0, "R3");

    // R5 read-only top bit, R1 out-of-range index
    acc(1, 0, 3'd2, 32'hFFFF_FFFF, "R5");
    acc(0, 0, 3'd2, 0, "R5");
    acc(0, 0, 3'd1, 0, "R1");
    acc(1, 0, 3'd0, 32'h1111_1111, "R1");

    // R6 search miss then hit
    srch(32'h0040_0000, 1'b0, 8'd0, "R6");
    acc(0, 0, 3'd2, 0, "R6");
    acc(1, 0, 3'd2, 32'd3, "R5");
    acc(0, 0, 3'd2, 0, "R5");
    srch(32'h0012_3000, 1'b1, 8'd5, "R6");
    acc(0, 0, 3'd2, 0, "R6");

    // R4 extended on wrong registers, R10 state kept, R7 bad codes
    acc(0, 1, 3'd3, 0, "R4");
    acc(1, 1, 3'd2, 32'd9, "R4");
    acc(0, 0, 3'd2, 0, "R10");
    acc(0, 0, 3'd5, 0, "R7");
    acc(0, 0, 3'd6, 0, "R7");
    acc(1, 0, 3'd7, 32'd1, "R7");
    acc(0, 0, 3'd2, 0, "R7");

    // R9 configuration gating
    cfg_tlb_acc = 2'd1;
    acc(1, 0, 3'd3, 32'h99, "R9");
    acc(1, 0, 3'd4, 32'h77, "R9");
    srch(32'h0000_1000, 1'b1, 8'd1, "R9");
    acc(0, 0, 3'd3, 0, "R9");
    acc(0, 0, 3'd4, 0, "R9");
    acc(1, 0, 3'd1, 32'h0BAD_F00D, "R9");
    cfg_tlb_acc = 2'd2;
    acc(0, 0, 3'd3, 0, "R9");
    acc(0, 0, 3'd1, 0, "R9");
    acc(0, 0, 3'd4, 0, "R9");
    acc(0, 0, 3'd0, 0, "R9");
    acc(0, 0, 3'd2, 0, "R9");
    acc(1, 0, 3'd4, 32'h55, "R9");
    cfg_tlb_acc = 2'd3;
    acc(0, 0, 3'd4, 0, "R9");
    acc(0, 0, 3'd1, 0, "R10");
    acc(0, 0, 3'd3, 0, "R10");

    // R8 global gate
    cfg_tlb_acc = 2'd0;
    acc(0, 0, 3'd2, 0, "R8");
    acc(1, 0, 3'd2, 32'd1, "R8");
    cfg_tlb_acc = 2'd3; cfg_level = 2'd1;
    acc(1, 0, 3'd2, 32'd2, "R8");
    acc(0, 0, 3'd2, 0, "R8");
    acc(1, 0, 3'd1, 32'hDEAD_BEEF, "R8");
    cfg_level = 2'd2;
    acc(0, 0, 3'd2, 0, "R10");
    acc(0, 0, 3'd1, 0, "R10");
    acc(0, 1, 3'd0, 0, "R10");

    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R12: act %0d results outstanding exp 0", q.size());
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule